// File: doc/BRIEF.md
# Frame-Synchronous Byte Descrambler

This block removes the additive line scrambling from a byte-parallel SONET/SDH receive stream, one byte per accepted beat. A 7-stage keystream generator built on the polynomial 1 + x^6 + x^7 is stepped eight bits per beat, and each keystream byte is XORed onto one data byte. The generator is forced to all ones at the same point of every frame, so the keystream is locked to frame position rather than to the bit history.

A start-of-frame flag marks the first framing byte of each frame. The framing and trace bytes of the first row (A1 group, A2 group, J0 group: `3*CHANNELS` bytes counted from the flagged byte) pass through unchanged. Descrambling starts on the byte that follows them. A bypass control is sampled only on the flagged byte, and the sampled value then holds for that whole frame.

Both stream edges use valid/ready. A beat transfers on a clock edge where valid and ready are both high. The input is ready whenever the single output register is empty or is being drained in that cycle. While the output is stalled (`out_valid` high, `out_ready` low), the output byte and its flag hold steady. The block has no other buffering.

Top module: `frame_descrambler`

## Requirements
- R1: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_data` and `out_sof` hold their values into the next cycle.
- R2: Each accepted input beat appears on the output one cycle after it is accepted. `out_sof` carries the beat's start-of-frame flag with the same delay.
- R3: The keystream generator is set to all ones for the first byte after the unscrambled overhead, and the first keystream bit goes to data bit 7. With all-zero payload, the first four output bytes of a frame are 8'hFE, 8'h04, 8'h18, 8'h51.
- R4: The beat flagged by `in_sof` and the next `3*CHANNELS-1` beats (the framing and trace bytes) are output unchanged.
- R5: `scr_off` is sampled only on the `in_sof` beat. When the sampled value is 1, every byte of that frame is output unchanged. Changes to `scr_off` in the middle of a frame have no effect until the next `in_sof` beat.
- R6: A new `in_sof` beat restarts the overhead count and the keystream, whatever position the previous frame had reached.
- R7: After reset and before the first `in_sof` beat, data is output unchanged.
- R8: Descrambling is an XOR with the keystream. A payload that has already been scrambled with the frame's keystream comes out as the original bytes.
- R9: During and right after reset, `out_valid` is 0 and `in_ready` is 1.
- R10: The keystream repeats every 127 bits. With all-zero payload, the output byte at payload offset i+127 equals the byte at offset i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Block can accept a byte |
| in_data | input | DATA_W | Received (scrambled) byte, bit 7 first on the line |
| in_sof | input | 1 | Marks the first framing byte of a frame |
| scr_off | input | 1 | Bypass request, sampled on the `in_sof` beat |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | DATA_W | Descrambled byte |
| out_sof | output | 1 | Start-of-frame flag delayed to match `out_data` |

## Verification
Every result is due one cycle after the input beat is accepted. A stalled output stays on the port until the cycle in which `out_ready` is sampled high. When a beat is accepted, the driver pushes the expected byte and flag, computed from a bit-serial model of the keystream and frame position. The monitor pops and compares only at falling edges where `out_valid` and `out_ready` are both high. This means the check follows the handshake and not a fixed count of edges, even while `out_ready` is being toggled. The stall-hold rule is checked separately, on consecutive falling edges during a stall.

// File: rtl/dscr_pkg.sv
package dscr_pkg;
  localparam int LFSR_W = 7;
  localparam logic [LFSR_W-1:0] SEED = '1;

  // Advance the x^7 + x^6 + 1 generator by nbits; the first bit lands in the MSB.
  function automatic logic [LFSR_W-1:0] lfsr_adv(input logic [LFSR_W-1:0] s_in, input int nbits);
    logic [LFSR_W-1:0] s;
    s = s_in;
    for (int i = 0; i < nbits; i++) s = {s[LFSR_W-2:0], s[6] ^ s[5]};
    return s;
  endfunction
endpackage

// File: rtl/dscr_frame_pos.sv
module dscr_frame_pos #(
  parameter int OH_BYTES = 144
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic sof,
  input  logic off_req,
  output logic is_oh,
  output logic pass
);
  localparam int CW = $clog2(OH_BYTES + 1);
  localparam logic [CW-1:0] OH_LIM = CW'(OH_BYTES);

  logic          locked;
  logic          off_frame;
  logic [CW-1:0] cnt;

  assign is_oh = sof || (locked && (cnt < OH_LIM));
  assign pass  = is_oh || !locked || off_frame;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked    <= 1'b0;
      off_frame <= 1'b0;
      cnt       <= '0;
    end else if (beat) begin
      if (sof) begin
        locked    <= 1'b1;
        off_frame <= off_req;
        cnt       <= CW'(1);
      end else if (locked && (cnt < OH_LIM)) begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/dscr_keygen.sv
module dscr_keygen
  import dscr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              reseed,
  output logic [DATA_W-1:0] key
);
  logic [LFSR_W-1:0] state;
  logic [LFSR_W-1:0] taps [DATA_W+1];

  assign taps[0] = state;
  for (genvar g = 0; g < DATA_W; g++) begin : g_look
    assign key[DATA_W-1-g] = taps[g][LFSR_W-1];
    assign taps[g+1]       = lfsr_adv(taps[g], 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      state <= SEED;
    else if (reseed) state <= SEED;
    else if (beat)   state <= taps[DATA_W];
  end
endmodule

// File: rtl/dscr_out_stage.sv
module dscr_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] d,
  input  logic              d_sof,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof
);
  logic accept;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= d;
      out_sof   <= d_sof;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/frame_descrambler.sv
module frame_descrambler #(
  parameter int DATA_W   = 8,
  parameter int CHANNELS = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              scr_off,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof
);
  localparam int OH_BYTES = 3 * CHANNELS;

  logic              beat, is_oh, pass;
  logic [DATA_W-1:0] key, mixed;

  assign beat  = in_valid && in_ready;
  assign mixed = pass ? in_data : (in_data ^ key);

  dscr_frame_pos #(.OH_BYTES(OH_BYTES)) u_pos (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(in_sof), .off_req(scr_off),
    .is_oh(is_oh), .pass(pass)
  );

  dscr_keygen #(.DATA_W(DATA_W)) u_key (
    .clk(clk), .rst_n(rst_n), .beat(beat), .reseed(beat && is_oh), .key(key)
  );

  dscr_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .d(mixed), .d_sof(in_sof), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sof(out_sof)
  );
endmodule

// File: rtl/frame_descrambler_chk.sv
module frame_descrambler_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              in_sof,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_sof
);
  a_r1_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r1_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof)));

  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && (out_sof == $past(in_sof))));

  a_r2_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !(in_valid && in_ready)) |=> !out_valid);

  a_r4_sof_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sof) |=> (out_data == $past(in_data)));
endmodule

bind frame_descrambler frame_descrambler_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_sof(in_sof), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof)
);

// File: tb/sim_frame_descrambler.sv
`timescale 1ns/1ps
module sim_frame_descrambler;
  localparam int CH = 2;
  localparam int OH = 3 * CH;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, scr_off = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_sof;
  logic [7:0] out_data;

  always #4 clk = ~clk;

  frame_descrambler #(.DATA_W(8), .CHANNELS(CH)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .scr_off(scr_off), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof)
  );

  int checks = 0, errors = 0;
  logic [7:0] q_data[$];
  logic       q_sof[$];
  string      q_tag[$];

  // bench reference model state
  logic       m_locked = 1'b0, m_off = 1'b0;
  int         m_pos = 0;
  logic [6:0] m_s = 7'h7f;
  logic [7:0] zero_run[0:127];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic key_byte(inout logic [6:0] s, output logic [7:0] k);
    for (int i = 7; i >= 0; i--) begin
      k[i] = s[6];
      s = {s[5:0], s[6] ^ s[5]};
    end
  endtask

  task automatic model(input logic [7:0] d, input logic sof, input logic off, output logic [7:0] e);
    logic [7:0] k;
    if (sof) begin m_locked = 1'b1; m_pos = 0; m_off = off; end
    if (!m_locked) e = d;
    else if (m_pos < OH) begin
      e = d; m_pos++;
      if (m_pos == OH) m_s = 7'h7f;
    end else begin
      key_byte(m_s, k);
      e = m_off ? d : (d ^ k);
    end
  endtask

  // driver: push the expected item at the handshake edge
  task automatic send(input logic [7:0] d, input logic sof, input logic off,
                      input bit use_lit, input logic [7:0] lit, input string tag);
    logic acc;
    logic [7:0] e;
    in_valid = 1'b1; in_data = d; in_sof = sof; scr_off = off;
    do begin
      @(negedge clk); acc = in_ready;
      @(posedge clk); #1;
    end while (!acc);
    model(d, sof, off, e);
    q_data.push_back(use_lit ? lit : e);
    q_sof.push_back(sof);
    q_tag.push_back(tag);
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  // mode 0: pattern payload, 1: zero payload, 2: pre-scrambled pattern (expect pattern)
  task automatic frame(input int nb, input logic off_sof, input logic off_mid,
                       input int mode, input string tag);
    logic [6:0] s = 7'h7f;
    logic [7:0] k, p;
    for (int i = 0; i < OH; i++)
      send(8'h30 + 8'(i), i == 0, off_sof, 1'b0, 8'h00, (i == 0) ? "R2 sof" : "R4 overhead");
    for (int i = 0; i < nb; i++) begin
      p = 8'((i * 37 + 11) & 255);
      key_byte(s, k);
      if (mode == 1) begin
        zero_run[i % 128] = 8'h00;
        send(8'h00, 1'b0, off_mid, i < 4, (i == 0) ? 8'hFE : (i == 1) ? 8'h04 : (i == 2) ? 8'h18 : 8'h51,
             (i < 4) ? "R3 first key bytes" : tag);
      end else if (mode == 2) begin
        send(p ^ k, 1'b0, off_mid, 1'b1, p, tag);
      end else begin
        send(p, 1'b0, off_mid, 1'b0, 8'h00, tag);
      end
    end
  endtask

  // monitor: pop and compare on every output transfer
  logic [7:0] out_log[0:255];
  int         out_n = 0;
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (q_data.size() == 0) check(1'b0, "R2 unexpected output", out_data, 0);
      else begin
        logic [7:0] ed; logic es; string t;
        ed = q_data.pop_front(); es = q_sof.pop_front(); t = q_tag.pop_front();
        check(out_data == ed, t, out_data, ed);
        check(out_sof == es, "R2 out_sof", out_sof, es);
        if (out_n < 256) out_log[out_n] = out_data;
        out_n++;
      end
    end
  end

  // stall hold check (R1)
  logic       st_prev = 1'b0;
  logic [7:0] st_data;
  always @(negedge clk) begin
    if (rst_n && st_prev) begin
      check(out_valid && out_data == st_data, "R1 stall hold", out_data, st_data);
      check(in_ready == out_ready, "R1 ready under stall", in_ready, out_ready);
    end
    st_prev = rst_n && out_valid && !out_ready;
    st_data = out_data;
  end

  bit stall_en = 1'b0;
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    #1 out_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
  end

  initial begin : main
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid && in_ready, "R9 reset state", {out_valid, in_ready}, 2'b01);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && in_ready, "R9 after reset", {out_valid, in_ready}, 2'b01);
        @(posedge clk); #1;
        for (int i = 0; i < 5; i++) send(8'hA0 + 8'(i), 1'b0, 1'b0, 1'b0, 8'h00, "R7 before first sof");
        out_n = 0;
        repeat (3) @(posedge clk); out_n = 0; #1;
        frame(140, 1'b0, 1'b0, 1, "R10 zero payload");
        repeat (3) @(posedge clk); #1;
        for (int i = 0; i < 13; i++)
          check(out_log[OH + i] == out_log[OH + i + 127], "R10 period 127",
                out_log[OH + i + 127], out_log[OH + i]);
        frame(20, 1'b1, 1'b0, 0, "R5 bypass frame, mid change ignored");
        frame(20, 1'b0, 1'b1, 0, "R5 scramble frame, mid change ignored");
        stall_en = 1'b1;
        frame(24, 1'b0, 1'b0, 0, "R1 payload under stall");
        stall_en = 1'b0;
        frame(24, 1'b0, 1'b0, 2, "R8 involution");
        frame(10, 1'b0, 1'b0, 0, "R6 short frame");
        frame(16, 1'b0, 1'b0, 2, "R6 restart after short frame");
        repeat (5) @(posedge clk);
        check(q_data.size() == 0, "R2 all outputs seen", q_data.size(), 0);
      end
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule